// File: doc/BRIEF.md
# Packet acquisition and start-delimiter search controller

This block sequences the front end of a spread-spectrum packet receiver. While idle it scans the antenna in dwells of a fixed number of symbol strobes. A carrier-sense hit on one strobe opens a short window in which a signal-quality hit on a later strobe declares detection. After detection the block waits a set number of symbols for the sync field to settle. It then pulses a seed request to the descrambler and opens a bounded search for the 16-bit start frame delimiter in the descrambled bit stream.

A delimiter match produces a one-cycle data-start pulse, and the controller goes back to scanning so that the payload datapath can take over. If no match arrives within the window counted from detection, the search closes and scanning resumes. The correlation, tracking and descrambling themselves sit outside the block. It only sees a symbol strobe, the two detector flags, and the descrambled bits with their valid strobe.

Top module: `dsss_acq_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, desc_seed_o, sfd_search_o and data_start_o are 0, the controller is scanning, and the next symbol strobe is index 0 of a dwell.
- R2: A dwell is DWELL_SYMS (default 10) symbol strobes. A carrier-sense hit (cs_i high on a strobe) while scanning opens a window that lasts until the last strobe of the following dwell.
- R3: Detection is sq_i high on a strobe that comes strictly after the carrier-sense strobe and inside its window. When the CS hit sits at dwell index p, the window is 19-p strobes with the defaults. sq_i on the same strobe as the CS hit does not count.
- R4: If the window closes without a signal-quality hit, the controller returns to scanning. A later sq_i alone then has no effect.
- R5: desc_seed_o pulses high for exactly one cycle, registered on the clock edge that samples the SEED_SYMS-th (default 16) strobe after the detecting strobe.
- R6: sfd_search_o is high from the cycle of the seed pulse until a match or timeout. The 16-bit delimiter shift register starts empty at each search, and only bits with rx_bit_vld_i high during the search enter it.
- R7: Bits arrive least significant first. When the last 16 accepted bits equal SFD_PATTERN (default 0xF3A0), with the first of them at bit 0, data_start_o pulses for one cycle, sfd_search_o drops in that same cycle, and scanning resumes.
- R8: If there is no match by the TIMEOUT_SYMS-th (default 72) strobe after detection, sfd_search_o drops on that strobe with no data-start pulse. A match completing on that same strobe still wins.
- R9: Bits delivered before the seed pulse or outside the search never contribute to a match.
- R10: After a timeout or a data start, scanning resumes with the dwell count restarted at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_stb_i | input | 1 | One-cycle strobe per received symbol |
| cs_i | input | 1 | Carrier-sense flag, sampled on strobes |
| sq_i | input | 1 | Signal-quality flag, sampled on strobes |
| rx_bit_i | input | 1 | Descrambled received bit |
| rx_bit_vld_i | input | 1 | Qualifies rx_bit_i |
| desc_seed_o | output | 1 | One-cycle request to seed the descrambler |
| sfd_search_o | output | 1 | High while the delimiter search is open |
| data_start_o | output | 1 | One-cycle pulse when the delimiter is found |

## Verification
The bench walks carrier-sense positions across the dwell and places the signal-quality hit exactly on and one past the window edge. A design that counted the window from the CS strobe rather than from the dwell boundary would accept or reject the wrong vectors. It also feeds 15 delimiter bits before the seed and one after, which a design that skipped clearing the shift register at the seed would wrongly accept. Timeout is probed one strobe early and on the boundary, and a match is completed on the very timeout strobe, where a design with the wrong priority would drop the packet. A fresh detection after timeout confirms that dwell counting restarts.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    ST_SCAN    = 2'd0,
    ST_CS_WAIT = 2'd1,
    ST_SYNC    = 2'd2,
    ST_SEARCH  = 2'd3
  } acq_state_e;
endpackage

// File: rtl/acq_dwell_timer.sv
module acq_dwell_timer #(
  parameter int DWELL_SYMS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic stb_i,
  output logic last_o
);
  localparam int CW = (DWELL_SYMS > 1) ? $clog2(DWELL_SYMS) : 1;
  localparam logic [CW-1:0] LAST = CW'(DWELL_SYMS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (stb_i)     cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST);
endmodule

// File: rtl/acq_sym_counter.sv
module acq_sym_counter #(
  parameter int SEED_SYMS    = 16,
  parameter int TIMEOUT_SYMS = 72
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  input  logic stb_i,
  output logic seed_hit_o,
  output logic timeout_hit_o
);
  localparam int CW = $clog2(TIMEOUT_SYMS + 1);
  localparam logic [CW-1:0] SEED_LAST = CW'(SEED_SYMS - 1);
  localparam logic [CW-1:0] TO_LAST   = CW'(TIMEOUT_SYMS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (clear_i)                      cnt_q <= '0;
    else if (run_i && stb_i && cnt_q != TO_LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign seed_hit_o    = run_i && stb_i && (cnt_q == SEED_LAST);
  assign timeout_hit_o = run_i && stb_i && (cnt_q == TO_LAST);
endmodule

// File: rtl/acq_sfd_matcher.sv
module acq_sfd_matcher #(
  parameter int              SFD_W       = 16,
  parameter logic [SFD_W-1:0] SFD_PATTERN = 16'hF3A0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic shift_i,
  input  logic bit_i,
  output logic match_o
);
  logic [SFD_W-1:0] sr_q, sr_d;

  // LSB-first: newest bit enters at the top, oldest ends at bit 0
  assign sr_d = {bit_i, sr_q[SFD_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (clear_i) sr_q <= '0;
    else if (shift_i) sr_q <= sr_d;
  end

  assign match_o = shift_i && !clear_i && (sr_d == SFD_PATTERN);
endmodule

// File: rtl/dsss_acq_ctrl.sv
module dsss_acq_ctrl
  import acq_pkg::*;
#(
  parameter int              DWELL_SYMS   = 10,
  parameter int              SEED_SYMS    = 16,
  parameter int              TIMEOUT_SYMS = 72,
  parameter int              SFD_W        = 16,
  parameter logic [SFD_W-1:0] SFD_PATTERN  = 16'hF3A0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sym_stb_i,
  input  logic cs_i,
  input  logic sq_i,
  input  logic rx_bit_i,
  input  logic rx_bit_vld_i,
  output logic desc_seed_o,
  output logic sfd_search_o,
  output logic data_start_o
);
  acq_state_e state_q, state_d;
  logic ends_q, ends_d;
  logic seed_q, seed_d, start_q, start_d;
  logic dwell_last, seed_hit, timeout_hit, match;
  logic cs_hit, sq_hit, dwell_end, in_pkt, detect;

  assign cs_hit    = sym_stb_i && cs_i;
  assign sq_hit    = sym_stb_i && sq_i;
  assign dwell_end = sym_stb_i && dwell_last;
  assign in_pkt    = (state_q == ST_SYNC) || (state_q == ST_SEARCH);
  assign detect    = (state_q == ST_CS_WAIT) && sq_hit;

  acq_dwell_timer #(.DWELL_SYMS(DWELL_SYMS)) u_dwell (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (in_pkt),
    .stb_i     (sym_stb_i),
    .last_o    (dwell_last)
  );

  acq_sym_counter #(.SEED_SYMS(SEED_SYMS), .TIMEOUT_SYMS(TIMEOUT_SYMS)) u_symcnt (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clear_i       (detect),
    .run_i         (in_pkt),
    .stb_i         (sym_stb_i),
    .seed_hit_o    (seed_hit),
    .timeout_hit_o (timeout_hit)
  );

  acq_sfd_matcher #(.SFD_W(SFD_W), .SFD_PATTERN(SFD_PATTERN)) u_sfd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (state_q != ST_SEARCH),
    .shift_i ((state_q == ST_SEARCH) && rx_bit_vld_i),
    .bit_i   (rx_bit_i),
    .match_o (match)
  );

  always_comb begin
    state_d = state_q;
    ends_d  = ends_q;
    seed_d  = 1'b0;
    start_d = 1'b0;
    unique case (state_q)
      ST_SCAN: begin
        if (cs_hit) begin
          state_d = ST_CS_WAIT;
          ends_d  = dwell_end;  // CS on the last strobe closes its own dwell
        end
      end
      ST_CS_WAIT: begin
        if (sq_hit) begin
          state_d = ST_SYNC;
        end else if (dwell_end) begin
          if (ends_q) state_d = ST_SCAN;
          else        ends_d  = 1'b1;
        end
      end
      ST_SYNC: begin
        if (seed_hit) begin
          state_d = ST_SEARCH;
          seed_d  = 1'b1;
        end
      end
      ST_SEARCH: begin
        if (match) begin
          state_d = ST_SCAN;
          start_d = 1'b1;
        end else if (timeout_hit) begin
          state_d = ST_SCAN;
        end
      end
      default: state_d = ST_SCAN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SCAN;
      ends_q  <= 1'b0;
      seed_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ends_q  <= ends_d;
      seed_q  <= seed_d;
      start_q <= start_d;
    end
  end

  assign desc_seed_o  = seed_q;
  assign data_start_o = start_q;
  assign sfd_search_o = (state_q == ST_SEARCH);
endmodule

// File: rtl/dsss_acq_ctrl_chk.sv
module dsss_acq_ctrl_chk #(
  parameter int SEARCH_SYMS = 56
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sym_stb_i,
  input logic rx_bit_vld_i,
  input logic desc_seed_o,
  input logic sfd_search_o,
  input logic data_start_o
);
  logic [15:0] srch_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       srch_cnt_q <= '0;
    else if (!sfd_search_o)            srch_cnt_q <= '0;
    else if (sym_stb_i && srch_cnt_q != 16'hFFFF) srch_cnt_q <= srch_cnt_q + 1'b1;
  end

  // R5
  a_r5_seed_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_seed_o |=> !desc_seed_o);

  // R6
  a_r6_search_opens_with_seed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sfd_search_o) |-> desc_seed_o);

  a_r6_seed_opens_search: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_seed_o |-> sfd_search_o);

  // R7
  a_r7_start_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_start_o |=> !data_start_o);

  a_r7_start_closes_search: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_start_o |-> (!sfd_search_o && $past(sfd_search_o) && $past(rx_bit_vld_i)));

  // R9
  a_r9_no_start_outside_search: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sfd_search_o) |-> !data_start_o);

  // R8
  a_r8_search_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srch_cnt_q <= 16'(SEARCH_SYMS));

  a_r1_pulses_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({desc_seed_o, data_start_o}));
endmodule

bind dsss_acq_ctrl dsss_acq_ctrl_chk #(
  .SEARCH_SYMS(TIMEOUT_SYMS - SEED_SYMS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sym_stb_i    (sym_stb_i),
  .rx_bit_vld_i (rx_bit_vld_i),
  .desc_seed_o  (desc_seed_o),
  .sfd_search_o (sfd_search_o),
  .data_start_o (data_start_o)
);

// File: tb/dsss_acq_ctrl_bench.sv
module dsss_acq_ctrl_bench;
  localparam int  SEED = 16;
  localparam int  TOUT = 72;
  localparam logic [15:0] SFD = 16'hF3A0;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sym_stb = 0, cs = 0, sq = 0, rx_bit = 0, rx_vld = 0;
  logic desc_seed, sfd_search, data_start;
  int   n_run = 0, n_fail = 0;
  int   cyc = 0;
  logic seen;

  always #10 clk = ~clk;

  dsss_acq_ctrl u_dsss_acq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .sym_stb_i(sym_stb), .cs_i(cs), .sq_i(sq),
    .rx_bit_i(rx_bit), .rx_bit_vld_i(rx_vld),
    .desc_seed_o(desc_seed), .sfd_search_o(sfd_search), .data_start_o(data_start)
  );

  // {cs dwell index[3:0], sq delay after cs[4:0], expect detect}
  localparam logic [9:0] VEC [8] = '{
    {4'd0, 5'd1,  1'b1}, {4'd0, 5'd19, 1'b1}, {4'd0, 5'd20, 1'b0},
    {4'd5, 5'd14, 1'b1}, {4'd5, 5'd15, 1'b0}, {4'd9, 5'd10, 1'b1},
    {4'd9, 5'd11, 1'b0}, {4'd3, 5'd8,  1'b1}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic c, input logic q, input logic v, input logic b);
    sym_stb = s; cs = c; sq = q; rx_vld = v; rx_bit = b;
    @(posedge clk); #1;
    sym_stb = 0; cs = 0; sq = 0; rx_vld = 0; rx_bit = 0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_ni = 1'b1;
  endtask

  // n strobes, returns whether any seed pulse appeared
  task automatic strobes(input int n, output logic any_seed);
    any_seed = 1'b0;
    for (int i = 0; i < n; i++) begin
      step(1, 0, 0, 0, 0);
      if (desc_seed) any_seed = 1'b1;
    end
  endtask

  task automatic detect_now();
    step(1, 1, 0, 0, 0);
    step(1, 0, 1, 0, 0);
  endtask

  task automatic send_sfd(input int nbits);
    for (int i = 0; i < nbits; i++) step(0, 0, 0, 1, SFD[i]);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    #1;
    // R1: held in reset
    check("R1 seed in reset", desc_seed, 1'b0);
    check("R1 search in reset", sfd_search, 1'b0);
    do_reset();
    check("R1 start after reset", data_start, 1'b0);

    // R2 R3 R4: window vectors
    foreach (VEC[k]) begin
      do_reset();
      repeat (int'(VEC[k][9:6])) step(1, 0, 0, 0, 0);
      step(1, 1, 0, 0, 0);
      repeat (int'(VEC[k][5:1]) - 1) step(1, 0, 0, 0, 0);
      step(1, 0, 1, 0, 0);
      strobes(SEED - 1, seen);
      check("R3 no early seed", seen, 1'b0);
      step(1, 0, 0, 0, 0);
      check(VEC[k][0] ? "R2 R3 detect in window" : "R4 no detect past window", desc_seed, VEC[k][0]);
    end

    // R3: SQ on the same strobe as CS does not detect
    do_reset();
    step(1, 1, 1, 0, 0);
    strobes(40, seen);
    check("R3 same-strobe sq", seen, 1'b0);

    // R5 R6 R7: full packet
    do_reset();
    detect_now();
    strobes(SEED - 1, seen);
    check("R5 seed not before count", seen, 1'b0);
    step(1, 0, 0, 0, 0);
    check("R5 seed pulse", desc_seed, 1'b1);
    check("R6 search open", sfd_search, 1'b1);
    step(0, 0, 0, 1, 1'b1);
    check("R5 seed one cycle", desc_seed, 1'b0);
    step(0, 0, 0, 1, 1'b0);
    step(0, 0, 0, 0, 1'b1);     // invalid bit ignored
    send_sfd(15);
    check("R7 no start before last bit", data_start, 1'b0);
    send_sfd_last: step(0, 0, 0, 1, SFD[15]);
    check("R7 data start", data_start, 1'b1);
    check("R7 search closes", sfd_search, 1'b0);
    step(0, 0, 0, 0, 0);
    check("R7 start one cycle", data_start, 1'b0);

    // R6 R9: bits before the seed do not count
    do_reset();
    detect_now();
    send_sfd(15);
    strobes(SEED, seen);
    check("R9 seed after early bits", seen, 1'b1);
    step(0, 0, 0, 1, SFD[15]);
    check("R9 early bits ignored", data_start, 1'b0);
    send_sfd(16);
    check("R6 fresh register matches", data_start, 1'b1);

    // R8 R10: timeout then re-acquire on a late dwell index
    do_reset();
    detect_now();
    strobes(SEED, seen);
    strobes(TOUT - SEED - 1, seen);
    check("R8 search open before timeout", sfd_search, 1'b1);
    step(1, 0, 0, 0, 0);
    check("R8 search closed at timeout", sfd_search, 1'b0);
    check("R8 no start at timeout", data_start, 1'b0);
    repeat (9) step(1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0);
    repeat (9) step(1, 0, 0, 0, 0);
    step(1, 0, 1, 0, 0);
    strobes(SEED, seen);
    check("R10 dwell restarted", seen, 1'b1);

    // R8: match completing on the timeout strobe wins
    do_reset();
    detect_now();
    strobes(TOUT - 1, seen);
    send_sfd(15);
    step(1, 0, 0, 1, SFD[15]);
    check("R8 match wins at timeout", data_start, 1'b1);

    // R1: reset during search
    do_reset();
    detect_now();
    strobes(SEED + 2, seen);
    rst_ni = 1'b0;
    #2;
    check("R1 async reset clears search", sfd_search, 1'b0);
    do_reset();

    finish_run();
  end
endmodule